// File: doc/BRIEF.md
# Register Init Command Sequencer

The sequencer runs a table of packed configuration commands. The table lives in a command memory, and a range of it is walked in order from a start index up to, but not including, an end index. Each entry occupies two 32-bit words. The sequencer decodes each entry and turns it into one of three kinds of traffic:

- accesses on a simple register master port, either single or burst;
- zero-fill descriptors on a block-transfer port;
- copy descriptors on the same block-transfer port.

Payload words for burst writes come from a separate data memory. Both memories have a one-cycle read latency.

Block transfers are split into descriptors of at most `CHUNK_MAX` words. Each descriptor moves the source and destination offsets forward by its length times four bytes. A transfer larger than the staging buffer (`BUF_BYTES`) is refused. Commands the block cannot run are flagged in a sticky error bit and skipped: the compressed-payload opcode and any unknown opcode. After the last command of the range finishes, a one-cycle done pulse is raised.

Top module: `init_cmd_seq`

## Requirements
- R1: Entry k sits at command word addresses 2k (word 0) and 2k+1 (word 1). Word 0 holds the opcode in bits [7:0] and a 24-bit target byte offset in bits [31:8]. Entries are executed one at a time, in increasing index order modulo 2^IDX_W, from `start_idx` up to `end_idx`-1.
- R2: The single-register opcodes each issue exactly one access at the target.
  - Opcode 1 issues a read (`bus_we`=0), and the returned data is discarded.
  - Opcode 2 writes word 1 with `bus_ind`=0.
  - Opcode 3 writes word 1 with `bus_ind`=1.
- R3: Opcodes 4 and 5 are burst writes. They take the length from word 1 bits [31:16] and the data-memory word offset from bits [15:0]. Beat i writes data word offset+i to target+4*i. Opcode 5 sets `bus_ind`=1 and opcode 4 clears it. A length of 0 issues nothing.
- R4: Opcode 6 zero-fills word-1 words at the target. It uses descriptors with `dma_zero`=1, where `dma_src` is the byte offset reached so far and `dma_dst` is the target plus that offset.
- R5: Opcode 8 copies word 1 bits [31:16] words. The source starts at data offset (word 1 bits [15:0]) times 4. Each descriptor has `dma_zero`=0, `dma_src` = start + reached offset and `dma_dst` = target + reached offset.
- R6: Each descriptor carries min(remaining, `CHUNK_MAX`) words, and offsets advance by that count times 4. A length of 0 issues no descriptor.
- R7: For opcodes 6 and 8, a length with length*4 > `BUF_BYTES` sets the error bit and issues no descriptor. A length with length*4 equal to `BUF_BYTES` is accepted.
- R8: Opcode 7, opcode 0 and opcodes above 8 set the error bit and issue nothing. The next entry is then executed normally.
- R9: A request on either port keeps all its fields stable until its ack. `bus_req` and `dma_req` are never high together.
- R10: `done` is high for exactly one cycle after the last entry completes. With `start_idx` = `end_idx`, `done` follows one cycle after start and no traffic is issued.
- R11: The error bit stays set after `done` until the next accepted start, which clears it.
- R12: During and right after reset, `done`, `err`, `bus_req`, `dma_req`, `cmd_rd` and `dat_rd` are low.
- R13: A start while a run is in progress is ignored, and the run's traffic is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| start_idx | input | IDX_W | First entry index |
| end_idx | input | IDX_W | Index one past the last entry |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error bit |
| cmd_rd | output | 1 | Command memory read enable |
| cmd_addr | output | IDX_W+1 | Command memory word address |
| cmd_rdata | input | 32 | Command word, one cycle after read |
| dat_rd | output | 1 | Data memory read enable |
| dat_addr | output | DAT_AW | Data memory word address |
| dat_rdata | input | 32 | Data word, one cycle after read |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_ind | output | 1 | Route the access through the indirect mailbox path |
| bus_addr | output | BUS_AW | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted this cycle |
| dma_req | output | 1 | Block-transfer descriptor valid |
| dma_zero | output | 1 | 1 = fill with zeros, 0 = copy |
| dma_src | output | BUS_AW | Source byte offset |
| dma_dst | output | BUS_AW | Destination byte address |
| dma_len | output | clog2(CHUNK_MAX+1) | Descriptor length in words |
| dma_ack | input | 1 | Descriptor accepted this cycle |

## Verification
The checks that run on every cycle cover several properties:
- both request ports hold their fields until acked, and never request together;
- every descriptor length is between 1 and `CHUNK_MAX`;
- a zero-fill descriptor stays inside the staging buffer;
- `done` is a single pulse and comes only while both ports are quiet.

The bench scenarios cover what needs the whole command table to judge. This includes the exact address, data and order of every beat and descriptor, and the chunk split at lengths below, at and above multiples of `CHUNK_MAX`. It also covers the buffer-size boundary, skipping a bad entry while later entries still run, error stickiness and clearing, index wrap-around, and a start arriving mid-run.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

  typedef enum logic [2:0] {
    K_SKIP  = 3'd0,
    K_READ  = 3'd1,
    K_WRITE = 3'd2,
    K_BURST = 3'd3,
    K_BLOCK = 3'd4
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_F0   = 4'd1,
    S_F1   = 4'd2,
    S_F2   = 4'd3,
    S_DISP = 4'd4,
    S_BUS  = 4'd5,
    S_DRD  = 4'd6,
    S_DLAT = 4'd7,
    S_BWR  = 4'd8,
    S_DMA  = 4'd9,
    S_NEXT = 4'd10,
    S_DONE = 4'd11
  } state_e;

  // Decoded view of one two-word entry
  typedef struct packed {
    kind_e        kind;
    logic         ind;
    logic         zero;
    logic         bad;
    logic [23:0]  tgt;
    logic [31:0]  val;
    logic [15:0]  doff;
    logic [31:0]  len;
  } dec_t;

  localparam logic [7:0] OPC_READ   = 8'd1;
  localparam logic [7:0] OPC_WRITE  = 8'd2;
  localparam logic [7:0] OPC_WRITEI = 8'd3;
  localparam logic [7:0] OPC_BURST  = 8'd4;
  localparam logic [7:0] OPC_BURSTI = 8'd5;
  localparam logic [7:0] OPC_FILL   = 8'd6;
  localparam logic [7:0] OPC_PACKED = 8'd7;
  localparam logic [7:0] OPC_COPY   = 8'd8;

endpackage

// File: rtl/iseq_decode.sv
// Pure decode of a fetched entry. Oversized block transfers and
// unsupported opcodes are folded into a single skip-with-error class.
module iseq_decode #(
  parameter int BUF_BYTES = 4096
) (
  input  logic [31:0]    w0,
  input  logic [31:0]    w1,
  output iseq_pkg::dec_t dec
);
  import iseq_pkg::*;

  localparam logic [33:0] BUF_LIM = 34'(BUF_BYTES);

  dec_t raw;

  always_comb begin
    raw      = '0;
    raw.kind = K_SKIP;
    raw.tgt  = w0[31:8];
    raw.val  = w1;
    raw.doff = w1[15:0];
    unique case (w0[7:0])
      OPC_READ:   raw.kind = K_READ;
      OPC_WRITE:  raw.kind = K_WRITE;
      OPC_WRITEI: begin raw.kind = K_WRITE; raw.ind = 1'b1; end
      OPC_BURST:  begin raw.kind = K_BURST; raw.len = {16'd0, w1[31:16]}; end
      OPC_BURSTI: begin
        raw.kind = K_BURST;
        raw.ind  = 1'b1;
        raw.len  = {16'd0, w1[31:16]};
      end
      OPC_FILL:   begin raw.kind = K_BLOCK; raw.zero = 1'b1; raw.len = w1; end
      OPC_COPY:   begin raw.kind = K_BLOCK; raw.len = {16'd0, w1[31:16]}; end
      default:    raw.bad = 1'b1;   // R8: includes the compressed-payload opcode
    endcase
  end

  // R7: staging buffer size check, done before any descriptor leaves
  always_comb begin
    dec = raw;
    if (raw.kind == K_BLOCK && ({raw.len, 2'b00} > BUF_LIM)) begin
      dec.kind = K_SKIP;
      dec.bad  = 1'b1;
    end
  end

endmodule

// File: rtl/iseq_span.sv
// Chunk walker for block transfers: remaining words and byte offset.
module iseq_span #(
  parameter int CHUNK_MAX = 256,
  parameter int BUS_AW    = 32,
  localparam int CHUNK_W  = $clog2(CHUNK_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic [31:0]        len_in,
  output logic [CHUNK_W-1:0] cur_len,
  output logic [BUS_AW-1:0]  off,
  output logic               last
);
  localparam logic [31:0]        MAX32 = 32'(CHUNK_MAX);
  localparam logic [CHUNK_W-1:0] MAXC  = CHUNK_W'(CHUNK_MAX);

  logic [31:0]       rem_q, rem_d;
  logic [BUS_AW-1:0] off_q, off_d;
  logic              en;

  // R6: descriptor size is the smaller of the remainder and the limit
  assign cur_len = (rem_q > MAX32) ? MAXC : rem_q[CHUNK_W-1:0];
  assign last    = (rem_q <= MAX32);
  assign off     = off_q;
  assign en      = load | adv;

  always_comb begin
    rem_d = rem_q;
    off_d = off_q;
    if (load) begin
      rem_d = len_in;
      off_d = '0;
    end else if (adv) begin
      rem_d = rem_q - 32'(cur_len);
      off_d = off_q + (BUS_AW'(cur_len) << 2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      off_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      off_q <= off_d;
    end
  end

endmodule

// File: rtl/init_cmd_seq.sv
// Table-driven register init sequencer (top).
module init_cmd_seq #(
  parameter int IDX_W     = 8,
  parameter int DAT_AW    = 16,
  parameter int BUS_AW    = 32,
  parameter int CHUNK_MAX = 256,
  parameter int BUF_BYTES = 4096,
  localparam int CMD_AW   = IDX_W + 1,
  localparam int CHUNK_W  = $clog2(CHUNK_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   start_idx,
  input  logic [IDX_W-1:0]   end_idx,
  output logic               done,
  output logic               err,
  output logic               cmd_rd,
  output logic [CMD_AW-1:0]  cmd_addr,
  input  logic [31:0]        cmd_rdata,
  output logic               dat_rd,
  output logic [DAT_AW-1:0]  dat_addr,
  input  logic [31:0]        dat_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic               bus_ind,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  output logic               dma_req,
  output logic               dma_zero,
  output logic [BUS_AW-1:0]  dma_src,
  output logic [BUS_AW-1:0]  dma_dst,
  output logic [CHUNK_W-1:0] dma_len,
  input  logic               dma_ack
);
  import iseq_pkg::*;

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  state_e            state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, end_q;
  logic              idx_en, end_en;
  logic [31:0]       w0_q, w1_q, wd_q;
  logic              w0_en, w1_en, wd_en;
  logic [15:0]       cnt_q, cnt_d;
  logic              cnt_en;
  logic              err_q, err_d, err_en;
  logic              span_load, span_adv, span_last;
  logic [CHUNK_W-1:0] span_len;
  logic [BUS_AW-1:0] span_off;
  dec_t              dec;

  iseq_decode #(.BUF_BYTES(BUF_BYTES)) u_dec (
    .w0  (w0_q),
    .w1  (w1_q),
    .dec (dec)
  );

  iseq_span #(.CHUNK_MAX(CHUNK_MAX), .BUS_AW(BUS_AW)) u_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (span_load),
    .adv     (span_adv),
    .len_in  (dec.len),
    .cur_len (span_len),
    .off     (span_off),
    .last    (span_last)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_en    = 1'b0;
    idx_d     = idx_q;
    end_en    = 1'b0;
    cnt_en    = 1'b0;
    cnt_d     = cnt_q;
    err_en    = 1'b0;
    err_d     = err_q;
    span_load = 1'b0;
    span_adv  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin                      // R13: only sampled here
          idx_en  = 1'b1;
          idx_d   = start_idx;
          end_en  = 1'b1;
          err_en  = 1'b1;                     // R11: start clears the error
          err_d   = 1'b0;
          state_d = (start_idx == end_idx) ? S_DONE : S_F0;   // R10
        end
      end
      S_F0: state_d = S_F1;
      S_F1: state_d = S_F2;
      S_F2: state_d = S_DISP;
      S_DISP: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        if (dec.bad) begin                    // R7, R8
          err_en  = 1'b1;
          err_d   = 1'b1;
          state_d = S_NEXT;
        end else begin
          unique case (dec.kind)
            K_READ, K_WRITE: state_d = S_BUS;
            K_BURST: state_d = (dec.len == '0) ? S_NEXT : S_DRD;
            K_BLOCK: begin
              span_load = 1'b1;
              state_d   = (dec.len == '0) ? S_NEXT : S_DMA;
            end
            default: state_d = S_NEXT;
          endcase
        end
      end
      S_BUS: if (bus_ack) state_d = S_NEXT;
      S_DRD: state_d = S_DLAT;
      S_DLAT: state_d = S_BWR;
      S_BWR: begin
        if (bus_ack) begin
          if ((cnt_q + 16'd1) == dec.len[15:0]) begin
            state_d = S_NEXT;
          end else begin
            cnt_en  = 1'b1;
            cnt_d   = cnt_q + 16'd1;
            state_d = S_DRD;
          end
        end
      end
      S_DMA: begin
        if (dma_ack) begin
          span_adv = 1'b1;
          if (span_last) state_d = S_NEXT;
        end
      end
      S_NEXT: begin
        idx_en  = 1'b1;
        idx_d   = idx_q + IDX_ONE;
        state_d = ((idx_q + IDX_ONE) == end_q) ? S_DONE : S_F0;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign w0_en = (state_q == S_F1);
  assign w1_en = (state_q == S_F2);
  assign wd_en = (state_q == S_DLAT);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      end_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      wd_q    <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (end_en) end_q <= end_idx;
      if (w0_en)  w0_q  <= cmd_rdata;
      if (w1_en)  w1_q  <= cmd_rdata;
      if (wd_en)  wd_q  <= dat_rdata;
      if (cnt_en) cnt_q <= cnt_d;
      if (err_en) err_q <= err_d;
    end
  end

  // Outputs, all driven from registered state (R9 stability)
  assign done     = (state_q == S_DONE);
  assign err      = err_q;

  assign cmd_rd   = (state_q == S_F0) || (state_q == S_F1);
  assign cmd_addr = {idx_q, (state_q == S_F1)};          // R1

  assign dat_rd   = (state_q == S_DRD);
  assign dat_addr = DAT_AW'(dec.doff) + DAT_AW'(cnt_q);  // R3

  assign bus_req   = (state_q == S_BUS) || (state_q == S_BWR);
  assign bus_we    = (state_q == S_BWR) || (dec.kind == K_WRITE);
  assign bus_ind   = dec.ind;
  assign bus_addr  = (state_q == S_BWR) ?
                     (BUS_AW'(dec.tgt) + (BUS_AW'(cnt_q) << 2)) :
                     BUS_AW'(dec.tgt);
  assign bus_wdata = (state_q == S_BWR) ? wd_q : dec.val;

  assign dma_req  = (state_q == S_DMA);
  assign dma_zero = dec.zero;
  assign dma_src  = dec.zero ? span_off :
                    ((BUS_AW'(dec.doff) << 2) + span_off); // R4, R5
  assign dma_dst  = BUS_AW'(dec.tgt) + span_off;
  assign dma_len  = span_len;

endmodule

// File: rtl/iseq_checker.sv
module iseq_checker #(
  parameter int BUS_AW    = 32,
  parameter int CHUNK_MAX = 256,
  parameter int BUF_BYTES = 4096,
  localparam int CHUNK_W  = $clog2(CHUNK_MAX + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic               cmd_rd,
  input logic               dat_rd,
  input logic               bus_req,
  input logic               bus_we,
  input logic               bus_ind,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_ack,
  input logic               dma_req,
  input logic               dma_zero,
  input logic [BUS_AW-1:0]  dma_src,
  input logic [BUS_AW-1:0]  dma_dst,
  input logic [CHUNK_W-1:0] dma_len,
  input logic               dma_ack
);

  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_we) && $stable(bus_ind));

  a_r9_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_src) && $stable(dma_dst)
                            && $stable(dma_len) && $stable(dma_zero));

  a_r9_one_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && dma_req));

  a_r6_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_len != '0) && (32'(dma_len) <= 32'(CHUNK_MAX)));

  a_r7_fill_in_buf: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_zero |-> (40'(dma_src) + (40'(dma_len) << 2)) <= 40'(BUF_BYTES));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req && !dma_req && !cmd_rd && !dat_rd);

endmodule

bind init_cmd_seq iseq_checker #(
  .BUS_AW(BUS_AW), .CHUNK_MAX(CHUNK_MAX), .BUF_BYTES(BUF_BYTES)
) u_iseq_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .cmd_rd(cmd_rd), .dat_rd(dat_rd),
  .bus_req(bus_req), .bus_we(bus_we), .bus_ind(bus_ind), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .dma_req(dma_req),
  .dma_zero(dma_zero), .dma_src(dma_src), .dma_dst(dma_dst),
  .dma_len(dma_len), .dma_ack(dma_ack)
);

// File: tb/tb_init_cmd_seq.sv
module tb_init_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;
  localparam int DAT_AW = 8;
  localparam int BUS_AW = 32;
  localparam int CHUNK_MAX = 4;
  localparam int BUF_BYTES = 64;
  localparam int CHUNK_W = $clog2(CHUNK_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0] start_idx = '0, end_idx = '0;
  logic done, err, cmd_rd, dat_rd, bus_req, bus_we, bus_ind, dma_req, dma_zero;
  logic [IDX_W:0] cmd_addr;
  logic [31:0] cmd_rdata = '0, dat_rdata = '0;
  logic [DAT_AW-1:0] dat_addr;
  logic [BUS_AW-1:0] bus_addr, dma_src, dma_dst;
  logic [31:0] bus_wdata;
  logic [CHUNK_W-1:0] dma_len;
  logic bus_ack = 1'b0, dma_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_cmd_seq #(.IDX_W(IDX_W), .DAT_AW(DAT_AW), .BUS_AW(BUS_AW),
                 .CHUNK_MAX(CHUNK_MAX), .BUF_BYTES(BUF_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .end_idx(end_idx), .done(done), .err(err), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata), .dat_rd(dat_rd),
    .dat_addr(dat_addr), .dat_rdata(dat_rdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_ind(bus_ind), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .dma_req(dma_req),
    .dma_zero(dma_zero), .dma_src(dma_src), .dma_dst(dma_dst),
    .dma_len(dma_len), .dma_ack(dma_ack));

  logic [31:0] cmd_mem [64];
  logic [31:0] dat_mem [256];

  always @(posedge clk) if (cmd_rd) cmd_rdata <= cmd_mem[cmd_addr];
  always @(posedge clk) if (dat_rd) dat_rdata <= dat_mem[dat_addr];

  // Logs of accepted traffic
  logic        a_we [256], a_ind [256], e_we [256], e_ind [256];
  logic [31:0] a_addr [256], a_data [256], e_addr [256], e_data [256];
  int          a_bn = 0, e_bn = 0;
  logic        a_zero [64], e_zero [64];
  logic [31:0] a_src [64], a_dst [64], a_len [64], e_src [64], e_dst [64], e_len [64];
  int          a_dn = 0, e_dn = 0;
  logic        e_err;

  logic [7:0] lf = 8'h5A;
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    bus_ack = lf[0] | lf[2];
    dma_ack = lf[1] | lf[4];
    if (bus_req && bus_ack && a_bn < 256) begin
      a_we[a_bn] = bus_we; a_ind[a_bn] = bus_ind;
      a_addr[a_bn] = bus_addr; a_data[a_bn] = bus_wdata; a_bn++;
    end
    if (dma_req && dma_ack && a_dn < 64) begin
      a_zero[a_dn] = dma_zero; a_src[a_dn] = dma_src;
      a_dst[a_dn] = dma_dst; a_len[a_dn] = 32'(dma_len); a_dn++;
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_cmd(input int idx, input logic [7:0] op,
                         input logic [23:0] tgt, input logic [31:0] w1);
    cmd_mem[2*idx]   = {tgt, op};
    cmd_mem[2*idx+1] = w1;
  endtask

  task automatic push_bus(input logic we, input logic ind,
                          input logic [31:0] addr, input logic [31:0] data);
    e_we[e_bn] = we; e_ind[e_bn] = ind; e_addr[e_bn] = addr; e_data[e_bn] = data;
    e_bn++;
  endtask

  task automatic push_blocks(input logic zero, input longint len,
                             input logic [31:0] src0, input logic [31:0] tgt);
    longint rem = len;
    longint o = 0;
    while (rem > 0) begin
      longint n = (rem > CHUNK_MAX) ? CHUNK_MAX : rem;
      e_zero[e_dn] = zero; e_src[e_dn] = src0 + 32'(o);
      e_dst[e_dn] = tgt + 32'(o); e_len[e_dn] = 32'(n); e_dn++;
      rem = rem - n; o = o + n * 4;
    end
  endtask

  // Bench-side interpretation of the table, written from the requirements
  task automatic model(input int s, input int e);
    int i = s;
    e_bn = 0; e_dn = 0; e_err = 1'b0;
    while (i != e) begin
      logic [31:0] w0 = cmd_mem[2*i];
      logic [31:0] w1 = cmd_mem[2*i+1];
      logic [31:0] tgt = {8'd0, w0[31:8]};
      longint ln;
      case (w0[7:0])
        8'd1: push_bus(1'b0, 1'b0, tgt, 32'd0);
        8'd2: push_bus(1'b1, 1'b0, tgt, w1);
        8'd3: push_bus(1'b1, 1'b1, tgt, w1);
        8'd4, 8'd5:
          for (int k = 0; k < int'(w1[31:16]); k++)
            push_bus(1'b1, w0[7:0] == 8'd5, tgt + 32'(4*k),
                     dat_mem[(int'(w1[15:0]) + k) & 255]);
        8'd6: begin
          ln = longint'(w1);
          if (ln * 4 > BUF_BYTES) e_err = 1'b1;
          else push_blocks(1'b1, ln, 32'd0, tgt);
        end
        8'd8: begin
          ln = longint'(w1[31:16]);
          if (ln * 4 > BUF_BYTES) e_err = 1'b1;
          else push_blocks(1'b0, ln, {14'd0, w1[15:0], 2'b00}, tgt);
        end
        default: e_err = 1'b1;
      endcase
      i = (i + 1) % 32;
    end
  endtask

  task automatic run(input int s, input int e, input string tag, input bit poke);
    int cyc = 0;
    model(s, e);
    @(negedge clk);
    a_bn = 0; a_dn = 0;
    start = 1'b1; start_idx = IDX_W'(s); end_idx = IDX_W'(e);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (s != e) chk(err == 1'b0, "R11 err cleared by start", 64'(err), 64'(0));
    while (!done && cyc < 4000) begin
      if (poke && cyc == 6) begin
        start = 1'b1; start_idx = IDX_W'(e); end_idx = IDX_W'(e);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, {tag, " R10 done seen"}, 64'(done), 64'(1));
    if (s == e) chk(cyc == 1, "R10 empty range latency", 64'(cyc), 64'(1));
    chk(err == e_err, {tag, " err"}, 64'(err), 64'(e_err));
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'(0));
    @(negedge clk);
    chk(err == e_err, "R11 err held after done", 64'(err), 64'(e_err));
    chk(a_bn == e_bn, {tag, " bus count"}, 64'(a_bn), 64'(e_bn));
    for (int k = 0; k < a_bn && k < e_bn; k++)
      chk(a_we[k] == e_we[k] && a_ind[k] == e_ind[k] && a_addr[k] == e_addr[k] &&
          (!e_we[k] || a_data[k] == e_data[k]), {tag, " bus beat"},
          {3'd0, a_we[k], 3'd0, a_ind[k], a_addr[k][23:0], a_data[k]},
          {3'd0, e_we[k], 3'd0, e_ind[k], e_addr[k][23:0], e_data[k]});
    chk(a_dn == e_dn, {tag, " descriptor count"}, 64'(a_dn), 64'(e_dn));
    for (int k = 0; k < a_dn && k < e_dn; k++)
      chk(a_zero[k] == e_zero[k] && a_src[k] == e_src[k] && a_dst[k] == e_dst[k] &&
          a_len[k] == e_len[k], {tag, " descriptor"},
          {a_zero[k], a_len[k][6:0], a_src[k][15:0], a_dst[k][23:0], 16'd0} >> 0,
          {e_zero[k], e_len[k][6:0], e_src[k][15:0], e_dst[k][23:0], 16'd0} >> 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++)
      dat_mem[a] = {8'hC3, 8'(a), 8'(a * 5), 8'(~a)};
    for (int a = 0; a < 64; a++) cmd_mem[a] = '0;

    repeat (3) @(negedge clk);
    chk({done, err, bus_req, dma_req, cmd_rd, dat_rd} == 6'b0, "R12 reset state",
        64'({done, err, bus_req, dma_req, cmd_rd, dat_rd}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, err, bus_req, dma_req, cmd_rd, dat_rd} == 6'b0, "R12 after release",
        64'({done, err, bus_req, dma_req, cmd_rd, dat_rd}), 64'(0));

    // Mixed table
    put_cmd(0,  8'd1, 24'h000123, 32'h0);
    put_cmd(1,  8'd2, 24'h00ABC0, 32'hDEADBEEF);
    put_cmd(2,  8'd3, 24'h000040, 32'h12345678);
    put_cmd(3,  8'd4, 24'h001000, {16'd3, 16'd5});
    put_cmd(4,  8'd5, 24'h002000, {16'd2, 16'd10});
    put_cmd(5,  8'd6, 24'h003000, 32'd9);
    put_cmd(6,  8'd8, 24'h004000, {16'd16, 16'd20});
    put_cmd(7,  8'd7, 24'h005000, {16'd4, 16'd0});
    put_cmd(8,  8'd0, 24'h006000, 32'h1);
    put_cmd(9,  8'd9, 24'h007000, 32'h1);
    put_cmd(10, 8'd6, 24'h008000, 32'd17);
    put_cmd(11, 8'd8, 24'h009000, {16'd0, 16'd3});
    put_cmd(12, 8'd4, 24'h00A000, {16'd0, 16'd3});
    put_cmd(13, 8'd2, 24'h000055, 32'hCAFE0001);
    put_cmd(30, 8'd2, 24'h0000F0, 32'hA0A0A0A0);
    put_cmd(31, 8'd3, 24'h0000F4, 32'hB1B1B1B1);

    run(0, 3, "R2", 1'b0);
    run(3, 5, "R3", 1'b0);
    run(5, 6, "R4", 1'b0);
    run(6, 7, "R5", 1'b0);
    run(7, 14, "R8", 1'b0);
    run(11, 14, "R11", 1'b0);
    run(30, 2, "R1", 1'b0);
    run(4, 4, "R10", 1'b0);
    run(0, 14, "R13", 1'b1);

    // Fill length sweep across chunk and buffer boundaries
    for (int L = 0; L <= 18; L++) begin
      put_cmd(20, 8'd6, 24'(32'h800 + L * 32'h100), 32'(L));
      run(20, 21, (L > 16) ? "R7" : ((L % CHUNK_MAX == 0) ? "R6" : "R4"), 1'b0);
    end
    // Copy length sweep
    for (int L = 0; L <= 17; L++) begin
      put_cmd(21, 8'd8, 24'(32'h4000 + L * 32'h40), {16'(L), 16'(L * 3)});
      run(21, 22, (L > 16) ? "R7" : "R5", 1'b0);
    end
    // Burst sweep, both paths
    for (int L = 0; L <= 6; L++) begin
      put_cmd(22, 8'd4, 24'(32'h100 + L * 32'h20), {16'(L), 16'(250 + L)});
      put_cmd(23, 8'd5, 24'(32'h900 + L * 32'h20), {16'(L), 16'(L * 7)});
      run(22, 24, "R3", 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule